// File: doc/BRIEF.md
# GPIO Interrupt Detect Unit

This block watches a bank of general-purpose pins (32 by default) and turns activity on them into per-pin interrupt status. Each pin is first brought into the clock domain through a two-stage synchronizer. It is then compared against a per-pin trigger kind chosen by two configuration bits: a trigger-style bit (edge or level) and a polarity bit. The encoding `{style, polarity}` gives four trigger kinds: falling edge (00), rising edge (01), low level (10) and high level (11). Detected events are held in a sticky status register. The status is gated by an enable register and reduced to a single cascade request for an upstream interrupt aggregator.

Software reaches five registers over a simple single-cycle bus. A write takes effect at the clock edge where `wr_en` is high. A read returns data on `rdata` one clock after `rd_en`. Status bits are acknowledged by writing a zero to them, so a read-modify-write is never needed to clear one source. Pins whose direction bit is 1 are outputs and take no part in detection. The direction bits are also presented on `dir_o` for the pad ring.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: Register offsets are 0 direction, 1 enable, 2 trigger style, 3 polarity, 4 status. Offsets 0 to 3 read back the last value written, and read data appears on `rdata` one clock after `rd_en`.
- R3: With style 0 and polarity 1, a 0-to-1 change on an input pin sets its status bit, and a 1-to-0 change does not.
- R4: With style 0 and polarity 0, a 1-to-0 change on an input pin sets its status bit, and a 0-to-1 change does not.
- R5: With style 1, a pin at the polarity's active level (1 for polarity 1, 0 for polarity 0) sets its status bit. The bit stays set after the pin goes inactive, until software clears it.
- R6: A write to offset 4 clears each status bit written as 0 and leaves each bit written as 1 unchanged. A detection in the same cycle still sets its bit.
- R7: A level-style source that is still active when its status bit is cleared sets that bit again by the next clock, so a later read shows it set.
- R8: Status bits are set whatever the enable register holds.
- R9: `irq_o` is the OR over all pins of status AND enable. With no enable bit set, it is low.
- R10: A pin whose direction bit is 1 never sets its status bit.
- R11: A pin change is seen by the unit on the third rising clock edge after it. With the pin's enable bit at 1, `irq_o` is still low after two edges and high after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Raw pin levels, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after `rd_en` |
| dir_o | output | 32 | Direction bits, 1 = output |
| irq_o | output | 1 | Cascade interrupt request |

## Verification
A table sweeps all four trigger kinds with both active and inactive pin transitions. The rising-edge and falling-edge swaps catch a unit with inverted polarity. The inactive transitions catch a detector that fires on any change. Directed tests then attack a partial clear: an inverted write mask would clear the wrong source or all of them. They also check a level source cleared while still active, which a design that lets the clear win outright would leave at 0. An output-direction pin is driven through an edge; a unit that ignores direction would latch it. The exact cycle of `irq_o` is checked, which exposes a missing or extra synchronizer stage.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register offsets on the configuration bus
    typedef enum logic [2:0] {
        REG_DIR  = 3'd0,
        REG_EN   = 3'd1,
        REG_STY  = 3'd2,
        REG_POL  = 3'd3,
        REG_STAT = 3'd4
    } reg_sel_e;

    // Trigger kind, encoded as {style, polarity}
    typedef enum logic [1:0] {
        TRIG_FALL = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_lane.sv
module gpio_irq_lane
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic style_bit,
    input  logic pol_bit,
    input  logic dir_bit,
    output logic event_o
);
    logic  prev_q;
    logic  hit;
    trig_e kind;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    assign kind = trig_e'({style_bit, pol_bit});

    always_comb begin
        hit = 1'b0;
        unique case (kind)
            TRIG_FALL: hit = prev_q & ~pin_s;
            TRIG_RISE: hit = ~prev_q & pin_s;
            TRIG_LOW:  hit = ~pin_s;
            TRIG_HIGH: hit = pin_s;
            default:   hit = 1'b0;
        endcase
        event_o = hit & ~dir_bit;
    end

    // R3: a rising edge is reported for a single cycle while the kind stays rising
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !style_bit && pol_bit) |=> (style_bit || !pol_bit || !event_o));

    // R4: a falling edge is reported for a single cycle while the kind stays falling
    p_fall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !style_bit && !pol_bit) |=> (style_bit || pol_bit || !event_o));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      events_i,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      en_q,
    output logic [N-1:0]      sty_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      stat_q
);
    reg_sel_e     sel;
    logic         stat_wr;
    logic [N-1:0] keep_mask;

    assign sel       = reg_sel_e'(addr[2:0]);
    assign stat_wr   = wr_en && (sel == REG_STAT);
    assign keep_mask = stat_wr ? wdata : '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            en_q  <= '0;
            sty_q <= '0;
            pol_q <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_DIR: dir_q <= wdata;
                REG_EN:  en_q  <= wdata;
                REG_STY: sty_q <= wdata;
                REG_POL: pol_q <= wdata;
                default: ;
            endcase
        end
    end

    // Set from detection wins over a zero written in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & keep_mask) | events_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (sel)
                REG_DIR:  rdata <= dir_q;
                REG_EN:   rdata <= en_q;
                REG_STY:  rdata <= sty_q;
                REG_POL:  rdata <= pol_q;
                REG_STAT: rdata <= stat_q;
                default:  rdata <= '0;
            endcase
        end
    end

    // R6: without a status write or detection, status holds
    p_stat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == REG_STAT) && events_i == '0) |=> stat_q == $past(stat_q));

    // R6: a status write with no detection keeps only bits written as 1
    p_stat_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en && addr == REG_STAT) && events_i == '0) |=> stat_q == ($past(stat_q) & $past(wdata)));

    // R8: every detected event lands in status, whatever the enables hold
    p_event_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (events_i != '0) |=> ((stat_q & $past(events_i)) == $past(events_i)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int N           = 32,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      pins_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      dir_o,
    output logic              irq_o
);
    logic [N-1:0] pins_s;
    logic [N-1:0] events;
    logic [N-1:0] dir_q, en_q, sty_q, pol_q, stat_q;

    gpio_irq_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i),
        .q_o   (pins_s)
    );

    for (genvar i = 0; i < N; i++) begin : g_lane
        gpio_irq_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_s     (pins_s[i]),
            .style_bit (sty_q[i]),
            .pol_bit   (pol_q[i]),
            .dir_bit   (dir_q[i]),
            .event_o   (events[i])
        );
    end

    gpio_irq_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .events_i (events),
        .rdata    (rdata),
        .dir_q    (dir_q),
        .en_q     (en_q),
        .sty_q    (sty_q),
        .pol_q    (pol_q),
        .stat_q   (stat_q)
    );

    assign dir_o = dir_q;
    assign irq_o = |(stat_q & en_q);

    // R9: nothing enabled means no request
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o);

    // R10: output-direction pins never report events
    p_out_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (events & dir_q) == '0);
endmodule

// File: tb/gpio_irq_detect_bench.sv
`timescale 1ns/1ps
module gpio_irq_detect_bench;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pins_i = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] dir_o;
    logic         irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_irq_detect u_gpio_irq_detect (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .dir_o(dir_o), .irq_o(irq_o)
    );

    // {style, polarity, pin before, pin after, expected status}
    localparam logic [4:0] VEC [8] = '{
        5'b01011, 5'b01100, 5'b00101, 5'b00010,
        5'b11011, 5'b11000, 5'b10101, 5'b10110
    };

    task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %h expected %h", 0, 1);
        finish_run();
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check(v == '0, "R1 reset register", v, '0);
        end
        check(irq_o == 1'b0, "R1 reset irq", N'(irq_o), '0);

        // R2: readback of configuration registers
        wr(3'd1, 32'h1234_5678); rd(3'd1, v);
        check(v == 32'h1234_5678, "R2 enable readback", v, 32'h1234_5678);
        wr(3'd3, 32'hA5A5_0F0F); rd(3'd3, v);
        check(v == 32'hA5A5_0F0F, "R2 polarity readback", v, 32'hA5A5_0F0F);
        wr(3'd0, 32'h0000_FF00); rd(3'd0, v);
        check(v == 32'h0000_FF00 && dir_o == 32'h0000_FF00, "R2 direction readback", v, 32'h0000_FF00);
        wr(3'd0, '0); wr(3'd1, '0); wr(3'd3, '0);

        // Table sweep: R3 R4 R5 with R8 (enable stays 0)
        for (int i = 0; i < 8; i++) begin
            int lane;
            logic [4:0] t;
            logic [N-1:0] exp;
            lane = (i * 5 + 1) % N;
            t = VEC[i];
            pins_i[lane] = t[2];
            settle();
            wr(3'd2, N'(t[4]) << lane);
            wr(3'd3, N'(t[3]) << lane);
            settle();
            wr(3'd4, '0);
            pins_i[lane] = t[1];
            settle();
            rd(3'd4, v);
            exp = N'(t[0]) << lane;
            check(v == exp, t[4] ? "R5 level vector" : (t[3] ? "R3 rise vector" : "R4 fall vector"), v, exp);
            check(irq_o == 1'b0, "R8 status set with enable 0", N'(irq_o), '0);
            wr(3'd2, '0); wr(3'd3, '0);
            pins_i[lane] = 1'b0;
            settle();
        end
        wr(3'd4, '0);

        // R11 and R9: latency to irq with enable
        wr(3'd3, 32'h0000_0088);
        wr(3'd1, 32'h0000_0008);
        wr(3'd4, '0);
        @(negedge clk);
        pins_i[3] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(irq_o == 1'b0, "R11 irq low after two edges", N'(irq_o), '0);
        @(posedge clk);
        @(negedge clk);
        check(irq_o == 1'b1, "R11 irq high after third edge", N'(irq_o), 1);
        wr(3'd1, '0);
        @(negedge clk);
        check(irq_o == 1'b0, "R9 irq off when enable cleared", N'(irq_o), '0);

        // R6: partial clear
        pins_i[7] = 1'b1;
        settle();
        rd(3'd4, v);
        check(v == 32'h0000_0088, "R6 two sources pending", v, 32'h0000_0088);
        wr(3'd4, ~32'h0000_0008);
        rd(3'd4, v);
        check(v == 32'h0000_0080, "R6 zero bit cleared only", v, 32'h0000_0080);
        wr(3'd1, 32'h0000_0080);
        @(negedge clk);
        check(irq_o == 1'b1, "R9 irq from remaining source", N'(irq_o), 1);
        wr(3'd1, '0);

        // R7: level source re-sets after clear
        wr(3'd2, 32'h0000_0400);
        wr(3'd3, 32'h0000_0488);
        pins_i[10] = 1'b1;
        settle();
        wr(3'd4, '0);
        rd(3'd4, v);
        check(v == 32'h0000_0400, "R7 level bit set again", v, 32'h0000_0400);
        pins_i[10] = 1'b0;
        settle();
        wr(3'd4, '0);
        rd(3'd4, v);
        check(v == '0, "R7 cleared once inactive", v, '0);

        // R10: output pin ignored
        wr(3'd2, '0);
        wr(3'd0, 32'h0000_1000);
        wr(3'd3, 32'h0000_1000);
        wr(3'd1, 32'h0000_1000);
        pins_i[12] = 1'b1;
        settle();
        rd(3'd4, v);
        check(v == '0, "R10 output pin status", v, '0);
        check(irq_o == 1'b0, "R10 output pin irq", N'(irq_o), '0);

        finish_run();
    end
endmodule